// File: doc/BRIEF.md
# RSS Hash Queue Selector

This block spreads received IPv4 traffic across receive queues. A parser upstream hands over the flow tuple of each packet with a 16-bit sideband word that describes the headers. The block computes a 32-bit Toeplitz hash of the tuple under a 16-byte secret key, one group of `STEP` tuple bits per cycle. The low bits of the hash then index an indirection table. Each table entry holds a destination queue ID and two buffer-pool selects. That entry, together with the hash, is offered on the output stream.

Software programs the enable and mode bits, the four key words and the table entries through a simple write port. It normally fills the table round-robin across the active queues. When the block is disabled, or the packet is not usable IPv4, hashing is skipped and table entry 0 is returned.

Both packet interfaces are valid/ready.
- Input side: only one packet is in flight at a time. `in_ready` is high only while the block is idle, and a packet is taken on a cycle with `in_valid` and `in_ready` both high.
- Output side: `out_valid` is held with stable data until the cycle `out_ready` is seen. The block is idle again on the following cycle.

Top module: `rss_qsel`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, the block is disabled and the key and all table entries are zero.
- R2: Register writes use word addresses. With the top address bit set, the low `IDX_W` bits select a table entry, laid out as qid = wdata[11:0], fp = wdata[15:12], nfp = wdata[19:16]. Otherwise address 0 is control, with bit 0 as enable and bits 2:1 as mode. Addresses 1 to 4 are key words, address 1 holding the most significant 32 key bits. Any other address is ignored.
- R3: The hash is Toeplitz. Starting at 0, for each tuple bit i taken MSB first (bit 95 is i = 0) that is set, the hash is XORed with key bits [127-i -: 32].
- R4: Sideband layout is IHL [4:0], MAC header length [10:5], protocol [12:11] (0 TCP, 1 UDP, 2 and 3 other), version [13] (0 IPv4) and fragment [14]. All 96 tuple bits are hashed only when mode is 0, fragment is 0 and protocol is TCP or UDP. Otherwise only the 64 address bits (tuple[95:32]) are hashed, which is the same as treating the ports as zero.
- R5: A packet with version not 0, or with IHL 0 (no IP header), bypasses hashing. It gives hash 0 and table entry 0.
- R6: When the enable bit is 0, every packet gives hash 0 and table entry 0, with `out_valid` rising 1 cycle after acceptance.
- R7: The output entry is the table entry indexed by hash[IDX_W-1:0].
- R8: A hashed packet raises `out_valid` exactly (bits/STEP)+2 cycles after acceptance, where bits is 96 or 64.
- R9: `in_ready` is low from acceptance until the output handshake, so `in_ready` and `out_valid` are never high together.
- R10: While `out_valid` is high without `out_ready`, every output holds its value. After the handshake cycle `out_valid` is 0 and `in_ready` is 1.
- R11: Key and control writes made after a packet is accepted do not change that packet's result. They take effect from the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Tuple and sideband valid |
| in_ready | output | 1 | Block idle, can take a packet |
| in_tuple | input | 96 | Source address, destination address, source port, destination port (MSB first) |
| in_sband | input | 16 | Header description word |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_qid | output | QID_W | Selected destination queue ID |
| out_fp | output | FP_W | Selected free-pool select |
| out_nfp | output | FP_W | Selected next free-pool select |
| out_hash | output | 32 | Hash value (0 on bypass) |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that the input and output are never both open, that results hold while stalled, and that the block releases after the handshake. It also checks that disabled and bad-header packets produce a zero hash exactly two edges after acceptance, and that the result latency is always one of the three legal values.

The correctness of the hash value itself, and the choice between 64 and 96 hashed bits, can only be shown by the bench scenarios. The same holds for table indexing and entry layout, for the immunity of an in-flight packet to key rewrites, and for ignored addresses. The bench compares these against its own Toeplitz model over sweeps of protocol, fragment, mode and many tuples.

// File: rtl/rss_pkg.sv
package rss_pkg;

  localparam int KEY_BITS   = 128;
  localparam int TUPLE_BITS = 96;
  localparam int ADDR_BITS  = 64;
  localparam int HASH_W     = 32;

  localparam logic [1:0] PROTO_TCP = 2'd0;
  localparam logic [1:0] PROTO_UDP = 2'd1;
  localparam logic [1:0] MODE_FULL = 2'd0;

  // header description word carried with each tuple
  typedef struct packed {
    logic       rsvd;
    logic       frag;
    logic       ver;
    logic [1:0] proto;
    logic [5:0] mac_len;
    logic [4:0] ihl;
  } sband_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HASH,
    ST_LOOK,
    ST_DONE
  } qsel_state_t;

endpackage

// File: rtl/rss_cfg_regs.sv
module rss_cfg_regs #(
  parameter int TBL_DEPTH = 16,
  parameter int IDX_W     = 4,
  parameter int ADDR_W    = 5,
  parameter int ENT_W     = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic                cfg_en,
  output logic [1:0]          cfg_mode,
  output logic [127:0]        key,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [ENT_W-1:0]    rd_entry
);
  localparam int LO_W = ADDR_W - 1;

  logic              tbl_hit;
  logic [LO_W-1:0]   lo_addr;
  logic [2:0]        ctrl_q;
  logic [31:0]       kword [4];
  logic [ENT_W-1:0]  tbl [TBL_DEPTH];

  assign tbl_hit = we && addr[ADDR_W-1];
  assign lo_addr = addr[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we && !addr[ADDR_W-1] && lo_addr == LO_W'(0)) begin
      ctrl_q <= wdata[2:0];
    end
  end

  for (genvar w = 0; w < 4; w++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        kword[w] <= '0;
      end else if (we && !addr[ADDR_W-1] && lo_addr == LO_W'(w + 1)) begin
        kword[w] <= wdata;
      end
    end
  end

  for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[e] <= '0;
      end else if (tbl_hit && addr[IDX_W-1:0] == IDX_W'(e)) begin
        tbl[e] <= wdata[ENT_W-1:0];
      end
    end
  end

  assign cfg_en   = ctrl_q[0];
  assign cfg_mode = ctrl_q[2:1];
  assign key      = {kword[0], kword[1], kword[2], kword[3]};
  assign rd_entry = tbl[rd_idx];

endmodule

// File: rtl/rss_sband_dec.sv
module rss_sband_dec
  import rss_pkg::*;
(
  input  logic [15:0] sband,
  input  logic [1:0]  mode,
  output logic        hdr_bad,
  output logic        use_ports
);
  sband_t sb;
  logic   unused_sb;

  assign sb        = sband_t'(sband);
  assign hdr_bad   = sb.ver || (sb.ihl == 5'd0);
  assign use_ports = (mode == MODE_FULL) && !sb.frag &&
                     (sb.proto == PROTO_TCP || sb.proto == PROTO_UDP);
  assign unused_sb = ^{sb.rsvd, sb.mac_len};

endmodule

// File: rtl/rss_toeplitz.sv
module rss_toeplitz
  import rss_pkg::*;
#(
  parameter int STEP = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  full,
  input  logic [KEY_BITS-1:0]   key_in,
  input  logic [TUPLE_BITS-1:0] tuple_in,
  output logic                  done,
  output logic [HASH_W-1:0]     hash
);
  localparam int N_FULL = TUPLE_BITS / STEP;
  localparam int N_ADDR = ADDR_BITS / STEP;
  localparam int CW     = $clog2(N_FULL + 1);

  logic [KEY_BITS-1:0]   ksr;
  logic [TUPLE_BITS-1:0] tsr;
  logic [HASH_W-1:0]     acc, acc_nxt;
  logic [CW-1:0]         cnt;
  logic                  busy;

  always_comb begin
    acc_nxt = acc;
    for (int j = 0; j < STEP; j++) begin
      if (tsr[TUPLE_BITS-1-j]) acc_nxt = acc_nxt ^ ksr[KEY_BITS-1-j -: HASH_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ksr  <= '0;
      tsr  <= '0;
      acc  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        ksr  <= key_in;
        tsr  <= tuple_in;
        acc  <= '0;
        cnt  <= full ? CW'(N_FULL) : CW'(N_ADDR);
        busy <= 1'b1;
      end else if (busy) begin
        acc <= acc_nxt;
        ksr <= ksr << STEP;
        tsr <= tsr << STEP;
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign hash = acc;

endmodule

// File: rtl/rss_qsel.sv
module rss_qsel
  import rss_pkg::*;
#(
  parameter int STEP      = 4,
  parameter int TBL_DEPTH = 16,
  parameter int QID_W     = 12,
  parameter int FP_W      = 4,
  localparam int IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
  localparam int ADDR_W   = ((IDX_W > 3) ? IDX_W : 3) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [95:0]       in_tuple,
  input  logic [15:0]       in_sband,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [QID_W-1:0]  out_qid,
  output logic [FP_W-1:0]   out_fp,
  output logic [FP_W-1:0]   out_nfp,
  output logic [31:0]       out_hash
);
  localparam int ENT_W = QID_W + 2 * FP_W;

  qsel_state_t          st;
  logic                 cfg_en;
  logic [1:0]           cfg_mode;
  logic [127:0]         key;
  logic [ENT_W-1:0]     entry;
  logic [HASH_W-1:0]    hash_r, h_hash;
  logic                 hdr_bad, use_ports, h_start, h_done, accept;

  rss_cfg_regs #(
    .TBL_DEPTH(TBL_DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .ENT_W(ENT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .key(key),
    .rd_idx(hash_r[IDX_W-1:0]), .rd_entry(entry)
  );

  rss_sband_dec u_dec (
    .sband(in_sband), .mode(cfg_mode), .hdr_bad(hdr_bad), .use_ports(use_ports)
  );

  rss_toeplitz #(.STEP(STEP)) u_hash (
    .clk(clk), .rst_n(rst_n), .start(h_start), .full(use_ports),
    .key_in(key), .tuple_in(in_tuple), .done(h_done), .hash(h_hash)
  );

  assign in_ready = (st == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign h_start  = accept && cfg_en && !hdr_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      hash_r    <= '0;
      out_valid <= 1'b0;
      out_qid   <= '0;
      out_fp    <= '0;
      out_nfp   <= '0;
      out_hash  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          if (h_start) begin
            st <= ST_HASH;
          end else begin
            hash_r <= '0;
            st     <= ST_LOOK;
          end
        end
        ST_HASH: if (h_done) begin
          hash_r <= h_hash;
          st     <= ST_LOOK;
        end
        ST_LOOK: begin
          out_valid <= 1'b1;
          out_qid   <= entry[QID_W-1:0];
          out_fp    <= entry[QID_W +: FP_W];
          out_nfp   <= entry[QID_W+FP_W +: FP_W];
          out_hash  <= hash_r;
          st        <= ST_DONE;
        end
        ST_DONE: if (out_ready) begin
          out_valid <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rss_qsel_chk.sv
module rss_qsel_chk
  import rss_pkg::*;
#(
  parameter int STEP  = 4,
  parameter int QID_W = 12,
  parameter int FP_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [15:0]      in_sband,
  input logic             out_valid,
  input logic             out_ready,
  input logic [QID_W-1:0] out_qid,
  input logic [FP_W-1:0]  out_fp,
  input logic [FP_W-1:0]  out_nfp,
  input logic [31:0]      out_hash,
  input logic             cfg_en
);
  localparam int L_FULL = TUPLE_BITS / STEP + 2;
  localparam int L_ADDR = ADDR_BITS / STEP + 2;

  sband_t     sb;
  logic       bad, acc, unused_chk;
  logic [7:0] lat_cnt;

  assign sb         = sband_t'(in_sband);
  assign bad        = sb.ver || (sb.ihl == 5'd0);
  assign acc        = in_valid && in_ready;
  assign unused_chk = ^{sb.rsvd, sb.frag, sb.proto, sb.mac_len};

  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '0;
    else if (acc) lat_cnt <= '0;
    else if (lat_cnt != 8'hff) lat_cnt <= lat_cnt + 8'd1;
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hash) && $stable(out_qid)
      && $stable(out_fp) && $stable(out_nfp));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cfg_en |=> !out_valid ##1 (out_valid && out_hash == 32'd0));

  p_bad_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad |=> !out_valid ##1 (out_valid && out_hash == 32'd0));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 8'd1 || lat_cnt == 8'(L_FULL) || lat_cnt == 8'(L_ADDR)));

endmodule

bind rss_qsel rss_qsel_chk #(.STEP(STEP), .QID_W(QID_W), .FP_W(FP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sband(in_sband), .out_valid(out_valid), .out_ready(out_ready),
  .out_qid(out_qid), .out_fp(out_fp), .out_nfp(out_nfp), .out_hash(out_hash),
  .cfg_en(cfg_en)
);

// File: tb/sim_rss_qsel.sv
module sim_rss_qsel;
  localparam int CLK_PERIOD = 10;
  localparam int STEP   = 4;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = 5;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [95:0] in_tuple = '0;
  logic [15:0] in_sband = '0;
  logic [11:0] out_qid;
  logic [3:0]  out_fp, out_nfp;
  logic [31:0] out_hash;

  int checks = 0, errors = 0;
  logic [2:0]   ctrl_m = '0;
  logic [127:0] key_m  = '0;
  logic [19:0]  tbl_m [DEPTH];
  logic [31:0]  rng = 32'h1234_5678;

  rss_qsel #(.STEP(STEP), .TBL_DEPTH(DEPTH), .QID_W(12), .FP_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_tuple(in_tuple), .in_sband(in_sband), .out_valid(out_valid),
    .out_ready(out_ready), .out_qid(out_qid), .out_fp(out_fp),
    .out_nfp(out_nfp), .out_hash(out_hash)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tz(input logic [127:0] k, input logic [95:0] t, input int nb);
    logic [31:0] h = '0;
    for (int i = 0; i < nb; i++) if (t[95-i]) h = h ^ k[127-i -: 32];
    return h;
  endfunction

  function automatic logic [15:0] sbw(input bit frag, input bit ver, input logic [1:0] proto,
                                     input logic [5:0] mac, input logic [4:0] ihl);
    return {1'b0, frag, ver, proto, mac, ihl};
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a[ADDR_W-1]) tbl_m[a[IDX_W-1:0]] = d[19:0];
    else case (a[ADDR_W-2:0])
      4'd0: ctrl_m = d[2:0];
      4'd1: key_m[127:96] = d;
      4'd2: key_m[95:64]  = d;
      4'd3: key_m[63:32]  = d;
      4'd4: key_m[31:0]   = d;
      default: ;
    endcase
  endtask

  task automatic run_pkt(input string tag, input logic [95:0] t, input logic [15:0] sb,
                         input int hold, input bit poke, input logic [31:0] pdata);
    bit byp, ports; int nb, elat, lat, wd; logic [31:0] eh; logic [19:0] ent;
    byp   = !ctrl_m[0] || sb[13] || (sb[4:0] == 5'd0);
    ports = (ctrl_m[2:1] == 2'd0) && !sb[14] && (sb[12:11] < 2'd2);
    nb    = ports ? 96 : 64;
    eh    = byp ? 32'd0 : tz(key_m, t, nb);
    elat  = byp ? 1 : nb / STEP + 2;
    ent   = tbl_m[eh[IDX_W-1:0]];
    @(negedge clk); in_tuple = t; in_sband = sb; in_valid = 1;
    wd = 0;
    while (!in_ready && wd < 1000) begin @(negedge clk); wd++; end
    @(posedge clk);
    @(negedge clk); in_valid = 0;
    check("R9", "in_ready while busy", {31'd0, in_ready}, 32'd0);
    if (poke) begin cfg_we = 1; cfg_addr = 5'd1; cfg_wdata = pdata; end
    lat = 0;
    while (!out_valid && lat < 300) begin @(negedge clk); cfg_we = 0; lat++; end
    cfg_we = 0;
    if (poke) key_m[127:96] = pdata;
    check(byp ? "R6" : "R8", "latency", lat, elat);
    check(tag, "hash", out_hash, eh);
    check("R7", "qid", {20'd0, out_qid}, {20'd0, ent[11:0]});
    check("R2", "fp/nfp", {24'd0, out_nfp, out_fp}, {24'd0, ent[19:12]});
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R10", "held hash", {out_valid, out_hash[30:0]}, {1'b1, eh[30:0]});
    end
    out_ready = 1; @(negedge clk); out_ready = 0;
    check("R10", "release", {30'd0, out_valid, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) tbl_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);
    run_pkt("R1", 96'h0a000001_0a000002_1234_5678, sbw(0,0,2'd0,6'd14,5'd5), 0, 0, 0);

    for (int i = 0; i < DEPTH; i++) wr({1'b1, 4'(i)}, {12'd0, 4'(15-i), 4'(i), 12'(12'h100 + i*7)});
    run_pkt("R6", 96'hc0a80001_c0a80002_0050_1f90, sbw(0,0,2'd0,6'd14,5'd5), 2, 0, 0);

    wr(5'd1, 32'h6d5a56da); wr(5'd2, 32'h255b0ec2);
    wr(5'd3, 32'h4167253d); wr(5'd4, 32'h43a38fb0);
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 4; p++)
        for (int f = 0; f < 2; f++) begin
          wr(5'd0, {29'd0, 2'(m), 1'b1});
          rng = nxt(rng); in_tuple[95:64] = rng;
          rng = nxt(rng); in_tuple[63:32] = rng;
          rng = nxt(rng);
          run_pkt("R4", {in_tuple[95:32], rng}, sbw(f[0],0,2'(p),6'd14,5'd5), 0, 0, 0);
        end

    wr(5'd0, 32'd1);
    run_pkt("R5", 96'h01020304_05060708_0102_0304, sbw(0,1,2'd0,6'd14,5'd5), 0, 0, 0);
    run_pkt("R5", 96'h01020304_05060708_0102_0304, sbw(0,0,2'd2,6'd14,5'd0), 0, 0, 0);

    for (int n = 0; n < 48; n++) begin
      logic [95:0] tt;
      rng = nxt(rng); tt[95:64] = rng;
      rng = nxt(rng); tt[63:32] = rng;
      rng = nxt(rng); tt[31:0]  = rng;
      run_pkt("R3", tt, sbw(0,0,2'(n % 2),6'd14,5'd5), n % 3, 0, 0);
    end

    run_pkt("R11", 96'h0a0a0a0a_0b0b0b0b_c000_0050, sbw(0,0,2'd0,6'd14,5'd5), 0, 1, 32'hdeadbeef);
    run_pkt("R11", 96'h0a0a0a0a_0b0b0b0b_c000_0050, sbw(0,0,2'd0,6'd14,5'd5), 0, 0, 0);

    wr(5'd5, 32'hffff_ffff); wr(5'd7, 32'h0);
    run_pkt("R2", 96'h11223344_55667788_99aa_bbcc, sbw(0,0,2'd1,6'd14,5'd5), 1, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule